// File: doc/BRIEF.md
# Pulse-Interval Burst Discriminator

This block turns a train of digital pulses into a clean binary level. Logic 1 is sent as a dense burst of pulses and logic 0 as sparser pulses. The block does not look at amplitude and does not filter. It measures the number of clock cycles between successive rising edges of `pulse_in` and classifies each interval. An interval of up to `short_max` cycles is short. An interval of up to twice that is a possible missed pulse. Anything longer ends the current run of pulses.

A run is accepted as a logic 1 once it has received enough pulses. A run with one missing pulse still counts as a single burst. Once a run is accepted, the block paints its whole extent into a delay line, back to the first pulse of the run. The delayed output therefore covers exactly the dense burst and nothing else. Sparse pulses that trail a burst never stretch it. A one-cycle strobe marks the moment of acceptance.

`pulse_in` must already be a clean logic level in the block's clock domain. The stream has no back-pressure: a pulse is taken in every cycle it arrives, and the output is a plain level with no ready input.

Top module: `burst_interval_discriminator`

## Requirements
- R1: The reset `rst_n` is synchronous and active low. While it is low, `bit_out` and `burst_valid` read 0. After reset has been released, the block holds no history, so the first rising edge is treated as the start of a new run.
- R2: `pulse_in` passes through SYNC_STAGES (2) flops. Only a 0-to-1 transition counts as a pulse, so a level held high for many cycles is one pulse. Each pulse must stay high for at least one cycle and low for at least one cycle.
- R3: The interval is the number of clock cycles between two successive rising edges. The interval counter stops at 2^CNT_W-1 (255) and never wraps, so a quiet gap of any length is classified as long.
- R4: An interval no larger than `short_max` (an unsigned cycle count) is short. An interval of exactly `short_max` is short; an interval of `short_max`+1 is not.
- R5: An interval of `short_max`+1 up to 2*`short_max` is a gap if it meets all of these conditions: it is the first gap in the run, and at least GAP_MIN_SHORT (3) short intervals have come before it in the run. A gap counts as one received pulse. If the next interval is short, the cycles across the gap are part of the output.
- R6: Any other interval starts a new run at that pulse and clears the counts. This covers an interval above 2*`short_max`, a second gap, and a gap that comes before 3 short intervals.
- R7: A run produces output only if a short interval brings its count of received pulses to MIN_PULSES (7) or more. A run with fewer pulses produces nothing.
- R8: For an accepted run, `bit_out` is high for one cycle per clock cycle from the run's first pulse through its last pulse that ends a short interval. The output is delayed by a fixed amount: a pulse first sampled high at clock edge j maps to the output cycle that begins at edge j+DELAY+1 (DELAY = 128).
- R9: A pulse after an accepted burst that is not itself followed by a short interval never extends `bit_out`.
- R10: `burst_valid` is high for exactly one cycle, beginning at edge j+2, where j is the edge that first samples high the pulse that caused acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Digital pulse train from the comparator |
| short_max | input | CNT_W | Largest interval, in cycles, that counts as short |
| bit_out | output | 1 | Recovered logic level, delayed by a fixed latency |
| burst_valid | output | 1 | One-cycle strobe when a burst is accepted |

## Verification
Two pieces of logic can act on the same rising edge. The first is gap bridging, which takes a pending gap into the output once the next short interval arrives. The second is acceptance, which paints the run into the delay line back to its first pulse. The stimulus includes a burst where the pulse right after a missing pulse is also the seventh received pulse, so both happen on one edge. Separately, a second burst starts on a long interval while the first burst is still moving through the delay line. In both cases a behavioural model of the intervals predicts the output, and that prediction is compared with `bit_out` and `burst_valid` on every clock.

// File: rtl/bd_pkg.sv
package bd_pkg;
  // Classification of one measured interval between rising edges
  typedef enum logic [1:0] {
    IV_SHORT = 2'd0,
    IV_GAP   = 2'd1,
    IV_LONG  = 2'd2
  } iv_class_e;
endpackage

// File: rtl/bd_edge_detect.sv
module bd_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic edge_det
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pulse_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  // R2: only a low-to-high transition of the synchronized level is a pulse
  assign edge_det = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/bd_interval_timer.sv
module bd_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_det,
  output logic [CNT_W-1:0] interval
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R3: cycles since the last edge, parked at TOP so it never wraps.
  // Reset parks it too, so the first edge after reset reads as long (R1).
  always_ff @(posedge clk) begin
    if (!rst_n)            interval <= TOP;
    else if (edge_det)     interval <= CNT_W'(1);
    else if (interval != TOP) interval <= interval + 1'b1;
  end
endmodule

// File: rtl/bd_run_tracker.sv
module bd_run_tracker
  import bd_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int MIN_PULSES    = 7,
  parameter int GAP_MIN_SHORT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_det,
  input  logic [CNT_W-1:0] interval,
  input  logic [CNT_W-1:0] short_max,
  output logic             fill_en,
  output logic [CNT_W-1:0] fill_len,
  output logic             accept_stb
);
  localparam int RUN_W = $clog2(MIN_PULSES + 1);
  localparam int SH_W  = $clog2(GAP_MIN_SHORT + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(MIN_PULSES);
  localparam logic [SH_W-1:0]  SH_TOP  = SH_W'(GAP_MIN_SHORT);
  localparam logic [CNT_W-1:0] AGE_TOP = '1;

  logic [RUN_W-1:0] run_cnt;      // received pulses in the current run
  logic [SH_W-1:0]  short_cnt;    // short intervals in the run, saturating
  logic             gap_used;     // the run already spent its one gap
  logic             accepted;     // the run reached MIN_PULSES
  logic [CNT_W-1:0] since_start;  // cycles since the run's first pulse
  logic [CNT_W-1:0] since_cov;    // cycles since the last painted pulse
  logic             accept_q;

  iv_class_e        cls;
  logic [CNT_W:0]   gap_lim;
  logic [RUN_W-1:0] run_inc;
  logic [SH_W-1:0]  short_inc;
  logic             accept_now;

  function automatic logic [CNT_W-1:0] age_step(input logic [CNT_W-1:0] v);
    return (v == AGE_TOP) ? AGE_TOP : v + 1'b1;
  endfunction

  always_comb begin
    gap_lim   = {1'b0, short_max} << 1;
    run_inc   = (run_cnt == RUN_TOP) ? RUN_TOP : run_cnt + 1'b1;
    short_inc = (short_cnt == SH_TOP) ? SH_TOP : short_cnt + 1'b1;
    // R4 short, R5 single tolerated gap, R6 everything else
    if (interval <= short_max)
      cls = IV_SHORT;
    else if (({1'b0, interval} <= gap_lim) && (short_cnt >= SH_TOP) && !gap_used)
      cls = IV_GAP;
    else
      cls = IV_LONG;
    // R7: acceptance only on a short interval that reaches the pulse count
    accept_now = edge_det && (cls == IV_SHORT) && !accepted && (run_inc >= RUN_TOP);
    // R8/R9: paint only on short intervals of an accepted run
    fill_en    = edge_det && (cls == IV_SHORT) && (accepted || accept_now);
    fill_len   = accepted ? since_cov : since_start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt     <= '0;
      short_cnt   <= '0;
      gap_used    <= 1'b0;
      accepted    <= 1'b0;
      since_start <= AGE_TOP;
      since_cov   <= AGE_TOP;
      accept_q    <= 1'b0;
    end else begin
      accept_q    <= accept_now;
      since_start <= age_step(since_start);
      since_cov   <= age_step(since_cov);
      if (edge_det) begin
        case (cls)
          IV_SHORT: begin
            run_cnt   <= run_inc;
            short_cnt <= short_inc;
            since_cov <= CNT_W'(1);
            if (accept_now) accepted <= 1'b1;
          end
          IV_GAP: begin
            // counted, but not painted until a short interval confirms it
            run_cnt  <= run_inc;
            gap_used <= 1'b1;
          end
          default: begin
            run_cnt     <= RUN_W'(1);
            short_cnt   <= '0;
            gap_used    <= 1'b0;
            accepted    <= 1'b0;
            since_start <= CNT_W'(1);
            since_cov   <= CNT_W'(1);
          end
        endcase
      end
    end
  end

  assign accept_stb = accept_q;  // R10
endmodule

// File: rtl/bd_env_line.sv
module bd_env_line #(
  parameter int DELAY = 128,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [LEN_W-1:0] fill_len,
  output logic             tap
);
  // cell i holds the envelope of the cycle i clocks ago
  logic [DELAY-1:0] cell_q;

  generate
    for (genvar i = 0; i < DELAY; i++) begin : g_cell
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) cell_q[0] <= 1'b0;
          else        cell_q[0] <= fill_en;
        end
      end else begin : g_body
        logic reach;
        assign reach = fill_en && (int'(fill_len) >= i);
        // R8: back-fill the cycles of the run up to fill_len clocks old
        always_ff @(posedge clk) begin
          if (!rst_n) cell_q[i] <= 1'b0;
          else        cell_q[i] <= cell_q[i-1] | reach;
        end
      end
    end
  endgenerate

  assign tap = cell_q[DELAY-1];
endmodule

// File: rtl/burst_interval_discriminator.sv
module burst_interval_discriminator #(
  parameter int CNT_W         = 8,
  parameter int DELAY         = 128,
  parameter int MIN_PULSES    = 7,
  parameter int GAP_MIN_SHORT = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] short_max,
  output logic             bit_out,
  output logic             burst_valid
);
  logic             edge_w;
  logic [CNT_W-1:0] interval_w;
  logic             fill_en_w;
  logic [CNT_W-1:0] fill_len_w;

  bd_edge_detect #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_in (pulse_in),
    .edge_det (edge_w)
  );

  bd_interval_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_det (edge_w),
    .interval (interval_w)
  );

  bd_run_tracker #(
    .CNT_W        (CNT_W),
    .MIN_PULSES   (MIN_PULSES),
    .GAP_MIN_SHORT(GAP_MIN_SHORT)
  ) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_det  (edge_w),
    .interval  (interval_w),
    .short_max (short_max),
    .fill_en   (fill_en_w),
    .fill_len  (fill_len_w),
    .accept_stb(burst_valid)
  );

  bd_env_line #(
    .DELAY(DELAY),
    .LEN_W(CNT_W)
  ) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .fill_en (fill_en_w),
    .fill_len(fill_len_w),
    .tap     (bit_out)
  );
endmodule

// File: rtl/bd_checker.sv
module bd_checker #(
  parameter int CNT_W = 8,
  parameter int DELAY = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_det,
  input logic [CNT_W-1:0] interval,
  input logic [CNT_W-1:0] short_max,
  input logic             fill_en,
  input logic             burst_valid,
  input logic             bit_out
);
  localparam int AW = $clog2(DELAY + 2) + 1;
  localparam logic [AW-1:0] AGE_TOP = '1;

  logic [AW-1:0]  since_acc;
  logic [CNT_W:0] wide_lim;
  assign wide_lim = {1'b0, short_max} << 1;

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_acc <= AGE_TOP;
    else if (burst_valid)       since_acc <= '0;
    else if (since_acc != AGE_TOP) since_acc <= since_acc + 1'b1;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |=> !burst_valid);  // R10
  AST_STROBE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> $past(fill_en));  // R7
  AST_FILL_ON_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (edge_det && (interval <= short_max)));  // R4
  AST_LONG_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && ({1'b0, interval} > wide_lim)) |-> !fill_en);  // R6
  AST_TIMER_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_det && (interval == '1)) |=> (interval == '1));  // R3
  AST_OUT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_out) |-> (since_acc <= AW'(DELAY)));  // R8
endmodule

bind burst_interval_discriminator bd_checker #(
  .CNT_W(CNT_W),
  .DELAY(DELAY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .edge_det   (edge_w),
  .interval   (interval_w),
  .short_max  (short_max),
  .fill_en    (fill_en_w),
  .burst_valid(burst_valid),
  .bit_out    (bit_out)
);

// File: tb/burst_interval_discriminator_test.sv
module burst_interval_discriminator_test;
  localparam int CNT_W = 8;
  localparam int DELAY = 128;
  localparam int MINP  = 7;
  localparam int GAPS  = 3;
  localparam int SMAX  = 8;
  localparam int N     = 2800;
  localparam int LAT   = DELAY + 2;
  localparam int SAT   = 255;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pulse_in;
  logic [CNT_W-1:0] short_max;
  logic             bit_out;
  logic             burst_valid;

  always #4 clk = ~clk;  // 125 MHz

  burst_interval_discriminator #(
    .CNT_W(CNT_W), .DELAY(DELAY), .MIN_PULSES(MINP), .GAP_MIN_SHORT(GAPS), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .short_max(short_max),
    .bit_out(bit_out), .burst_valid(burst_valid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit lvl  [N];
  bit cov  [N];
  bit strb [N+8];

  task automatic put(input int t, input int w);
    for (int i = 0; i < w; i++) lvl[t+i] = 1'b1;
  endtask

  task automatic train(input int t0, input int sp, input int np, input int w);
    for (int i = 0; i < np; i++) put(t0 + i*sp, w);
  endtask

  task automatic mark(input int a, input int b);
    for (int i = a; i <= b; i++) cov[i] = 1'b1;
  endtask

  // behavioural model over the rising-edge times of the stimulus
  task automatic build_model();
    int prev = -1; int run_start = 0; int run_cnt = 0; int shorts = 0; int last_cov = 0;
    bit gap_used = 0; bit acc = 0; int iv;
    for (int t = 0; t < N; t++) begin
      if (lvl[t] && (t == 0 || !lvl[t-1])) begin
        iv = (prev < 0 || t - prev > SAT) ? SAT : t - prev;
        if (iv <= SMAX) begin
          run_cnt++; shorts++;
          if (acc) begin mark(last_cov, t); end
          else if (run_cnt >= MINP) begin acc = 1; mark(run_start, t); strb[t+3] = 1'b1; end
          last_cov = t;
        end else if (iv <= 2*SMAX && shorts >= GAPS && !gap_used) begin
          run_cnt++; gap_used = 1;
        end else begin
          run_start = t; run_cnt = 1; shorts = 0; gap_used = 0; acc = 0; last_cov = t;
        end
        prev = t;
      end
    end
  endtask

  function automatic string tag_of(input int s);
    if (s < 70)   return "R8 dense burst";
    if (s < 150)  return "R9 sparse tail";
    if (s < 300)  return "R5 bridged gap";
    if (s < 500)  return "R5 gap bridged with accept";
    if (s < 700)  return "R7 short run";
    if (s < 900)  return "R6 early gap";
    if (s < 1150) return "R6 second gap";
    if (s < 1550) return "R2 wide and held pulses";
    if (s < 2050) return "R3 counter saturation";
    if (s < 2450) return "R4 threshold edge";
    return "R8 back-to-back bursts";
  endfunction

  task automatic chk(input logic act, input bit exp, input string req, input int m);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s slot %0d: actual %b expected %b", req, m, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; pulse_in = 1'b0; short_max = CNT_W'(SMAX);
    train(20, 6, 8, 1);                 // accepted burst
    put(74, 1); put(86, 1); put(98, 1); // sparse pulses after it
    train(200, 6, 4, 1); train(230, 6, 4, 1);       // one pulse missing
    train(400, 6, 5, 1); put(436, 1); put(442, 1); put(448, 1);
    train(600, 6, 6, 1);                // six pulses only
    train(800, 6, 3, 1); train(824, 6, 8, 1);
    train(1000, 6, 5, 1); put(1036, 1); put(1042, 1); put(1048, 1);
    put(1060, 1); put(1066, 1); put(1072, 1);
    train(1200, 8, 8, 3);               // wide pulses
    put(1400, 40);                      // one long high level
    train(1600, 6, 6, 1); put(1892, 1); // gap past saturation
    train(2100, 8, 8, 1);               // interval equal to threshold
    train(2300, 9, 8, 1);               // one above threshold
    train(2500, 6, 8, 1); train(2559, 6, 8, 1);
    build_model();

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(bit_out, 1'b0, "R1 reset", -1);
    chk(burst_valid, 1'b0, "R1 reset", -1);
    rst_n = 1'b1;
    pulse_in = lvl[0];
    for (int m = 1; m < N; m++) begin
      @(posedge clk);
      @(negedge clk);
      chk(bit_out, (m >= LAT) ? cov[m-LAT] : 1'b0,
          (m >= LAT) ? tag_of(m - LAT) : "R1 quiet after reset", m);
      chk(burst_valid, strb[m], "R10 strobe", m);
      pulse_in = lvl[m];
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule